// File: doc/BRIEF.md
# Daisy-Chainable 16-bit Serial Configuration Slave

This block is a serial slave that takes 16-bit command words from a host over a four-wire serial link. It stores each word in one of six configuration registers. The top three bits of a word pick the register, and the low thirteen bits are its payload. The serial pins are sampled into the system clock domain, and every decision is made there. The system clock has to run at least four times faster than the serial clock.

While the slave is selected, it shifts out a status word taken from a parallel input. If the host keeps clocking past sixteen bits, the serial output repeats what came in sixteen bits earlier. Several slaves can then be chained in a ring, each one passing its predecessor's words along. When the select line is released, only the most recent complete word is committed. A frame whose length is not a whole number of words changes nothing.

Top module: `spi_cfg_slave`

## Requirements
- R1: Serial input is sampled on each falling serial clock edge while `cs_n` is low. A word is sent most significant bit first. Once `cs_n` returns high after a 16-bit frame whose bits 15:13 hold address a < 6, register a holds bits 12:0 of that word. Register a sits at `cfg_regs[a*13 +: 13]`.
- R2: No register changes while `cs_n` is still low, even after sixteen or more bits have been clocked in.
- R3: A frame of 0, 15 or 17 bits, or any length that is not a multiple of 16, leaves every register unchanged.
- R4: After a frame of 32 bits, only the second word is committed. The first word has no effect unless it shares the second word's address.
- R5: A complete word whose address field is 6 or 7 changes no register.
- R6: The 16 bits shifted out first on `sdo` are `status_in` as sampled at the first rising serial clock edge of the frame, most significant bit first. Each bit is valid from its rising edge until the next falling edge.
- R7: From the 17th rising edge on, `sdo` repeats the serial input bits in the order they were received, delayed by 16 bits.
- R8: `sdo` is high impedance whenever `cs_n` is high.
- R9: After reset, all six registers read zero.
- R10: A change of `status_in` after the first rising edge of a frame does not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, tri-stated while deselected |
| status_in | input | 16 | Status word reported in the first 16 output bits |
| cfg_regs | output | 78 | Six 13-bit registers, register i at bits i*13+12 : i*13 |

## Verification
The main function is tried with single-word frames for every legal address, using payloads of all ones, all zeros and alternating patterns. These show that the address decode and bit ordering are right and that writes do not spill into a neighbouring register. Words with addresses 6 and 7 show that invalid addresses are discarded. Frames of 0, 15, 17 and 32 bits separate a proper multiple-of-16 check from a simple "at least sixteen" check, and show that the last word wins over the first. The output stream is compared against a status word and then against the delayed input to confirm the daisy-chain path. A status input that changes partway through a frame shows whether the status word is sampled once or read live.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int NUM_REGS = 6;
  localparam int CNT_W    = $clog2(WORD_W);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_s,
  input  logic  sclk_s,
  input  logic  sdi_s,
  input  word_t status_in,
  output logic  tx_bit,
  output logic  commit,
  output word_t commit_word
);
  logic             cs_q, sclk_q;
  logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic             full, first_rise;
  word_t            rx_sr, tx_sr;

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign sclk_fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      bit_cnt     <= '0;
      full        <= 1'b0;
      first_rise  <= 1'b0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      commit      <= 1'b0;
      commit_word <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      commit <= 1'b0;
      if (cs_fall) begin
        bit_cnt    <= '0;
        full       <= 1'b0;
        first_rise <= 1'b1;
      end else if (!cs_s) begin
        if (sclk_fall) begin
          rx_sr   <= {rx_sr[WORD_W-2:0], sdi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(WORD_W-1)) full <= 1'b1;
        end
        if (sclk_rise) begin
          if (first_rise) begin
            tx_sr      <= status_in;
            first_rise <= 1'b0;
          end else begin
            tx_sr <= {tx_sr[WORD_W-2:0], rx_sr[0]};
          end
        end
      end
      if (cs_rise && full && bit_cnt == '0) begin
        commit      <= 1'b1;
        commit_word <= rx_sr;
      end
    end
  end

  assign tx_bit = tx_sr[WORD_W-1];

  // R1: the bit counter moves only on a serial clock fall or a new frame
  p_cnt_only_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (!cs_fall && !sclk_fall) |=> $stable(bit_cnt));
  // R3: each new frame restarts counting with no word held
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (bit_cnt == '0 && !full));
  // R6: the first rising edge captures the status word
  p_status_load_r6: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !cs_s && !cs_fall && first_rise) |=> tx_sr == $past(status_in));
  // R7: later rising edges feed the newest received bit into the output line
  p_echo_r7: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !cs_s && !cs_fall && !first_rise) |=> tx_sr[0] == $past(rx_sr[0]));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  word_t                     wr_word,
  output logic [NUM_REGS*PAY_W-1:0] regs_flat
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  payload;

  assign addr    = wr_word[WORD_W-1 -: ADDR_W];
  assign payload = wr_word[PAY_W-1:0];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) regs_flat[i*PAY_W +: PAY_W] <= '0;
        else if (wr_en && addr == ADDR_W'(i)) regs_flat[i*PAY_W +: PAY_W] <= payload;
      end
    end
  endgenerate

  // R2: without a commit pulse every register holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_flat));
  // R5: an out-of-range address writes nothing
  p_bad_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdi,
  output logic                      sdo,
  input  logic [WORD_W-1:0]         status_in,
  output logic [NUM_REGS*PAY_W-1:0] cfg_regs
);
  logic [2:0] pins_s;
  logic       tx_bit, commit;
  word_t      commit_word;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  spi_frame_shifter u_shift (
    .clk(clk), .rst(rst),
    .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .status_in(status_in),
    .tx_bit(tx_bit), .commit(commit), .commit_word(commit_word)
  );

  spi_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(commit), .wr_word(commit_word),
    .regs_flat(cfg_regs)
  );

  assign sdo = cs_n ? 1'bz : tx_bit;
endmodule

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HCLK = 6;
  localparam int NREG = 6;
  localparam int PW = 13;
  localparam int NVEC = 10;
  // {word, status, expected index (7 = none), expected payload}
  localparam logic [47:0] VEC [NVEC] = '{
    {3'd0, 13'h0A5C, 16'hC3A5, 3'd0, 13'h0A5C},
    {3'd1, 13'h1555, 16'h8001, 3'd1, 13'h1555},
    {3'd2, 13'h0AAA, 16'h7FFE, 3'd2, 13'h0AAA},
    {3'd3, 13'h1FFF, 16'h1234, 3'd3, 13'h1FFF},
    {3'd4, 13'h0001, 16'hFFFF, 3'd4, 13'h0001},
    {3'd5, 13'h1000, 16'h0000, 3'd5, 13'h1000},
    {3'd6, 13'h1FFF, 16'hA5A5, 3'd7, 13'h0000},
    {3'd7, 13'h1234, 16'h5A5A, 3'd7, 13'h0000},
    {3'd0, 13'h1FFF, 16'h0F0F, 3'd0, 13'h1FFF},
    {3'd5, 13'h0000, 16'hF0F0, 3'd5, 13'h0000}
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] status_in = 16'h0;
  wire  sdo;
  logic [NREG*PW-1:0] cfg_regs;
  logic [PW-1:0] model [NREG];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0, sdo_hiz;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_slave u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
                    .sdo(sdo), .status_in(status_in), .cfg_regs(cfg_regs));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) check(req, 64'(cfg_regs[i*PW +: PW]), 64'(model[i]));
  endtask

  // clocks nbits bits from data (MSB of the nbits first); returns sdo bits
  task automatic send(input int nbits, input logic [63:0] data, input bit flip,
                      input bit mid_chk, output logic [63:0] got);
    got = '0;
    cs_n = 1'b0;
    wait_clk(HCLK);
    for (int k = 0; k < nbits; k++) begin
      sdi = data[nbits-1-k];
      wait_clk(HCLK);
      sclk = 1'b1;
      wait_clk(HCLK);
      got = {got[62:0], sdo};
      if (flip && k == 0) status_in = ~status_in;
      sclk = 1'b0;
      wait_clk(HCLK);
    end
    if (mid_chk) check_regs("R2");
    cs_n = 1'b1;
    wait_clk(3 * HCLK);
  endtask

  initial begin
    logic [63:0] got;
    logic [15:0] w1, w2;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    check_regs("R9");
    check("R8", 64'(sdo === 1'bz), 64'd1);

    // table walk: R1 writes, R5 bad addresses, R6 status stream
    for (int v = 0; v < NVEC; v++) begin
      status_in = VEC[v][31:16];
      send(16, 64'(VEC[v][47:32]), 1'b0, 1'b0, got);
      if (VEC[v][15:13] != 3'd7) model[VEC[v][15:13]] = VEC[v][12:0];
      check("R6", got[15:0], 64'(VEC[v][31:16]));
      check_regs(VEC[v][15:13] == 3'd7 ? "R5" : "R1");
      check("R8", 64'(sdo === 1'bz), 64'd1);
    end

    // R3: frames of 0, 15 and 17 bits change nothing
    send(0, 64'h0, 1'b0, 1'b0, got);
    check_regs("R3");
    send(15, 64'h7FFF, 1'b0, 1'b0, got);
    check_regs("R3");
    send(17, {47'h0, 17'h0_2AAA}, 1'b0, 1'b0, got);
    check_regs("R3");

    // R4 + R7 + R2: 32-bit frame, second word wins, first word echoed
    w1 = {3'd1, 13'h0F0F};
    w2 = {3'd2, 13'h1248};
    status_in = 16'hBEEF;
    send(32, {32'h0, w1, w2}, 1'b0, 1'b1, got);
    model[2] = 13'h1248;
    check_regs("R4");
    check("R6", got[31:16], 64'hBEEF);
    check("R7", got[15:0], 64'(w1));

    // R10: status changed after first rising edge is not seen
    status_in = 16'h9C3A;
    send(16, 64'({3'd4, 13'h0777}), 1'b1, 1'b0, got);
    model[4] = 13'h0777;
    check("R10", got[15:0], 64'h9C3A);
    check_regs("R1");

    // R9: reset clears registers again
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);
    for (int i = 0; i < NREG; i++) model[i] = '0;
    check_regs("R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule